// File: doc/BRIEF.md
# Power Mode and Clock Divider Controller

This block sets the core clock rate and the power state of a processor subsystem from one fast reference clock. A control register supplies a 3-bit divide code and a 3-bit operating-mode code together with a load strobe. The divide code picks a power-of-two ratio from 1 to 128. The block produces a one-cycle core clock enable at that rate, so logic downstream runs on the reference clock and advances only when the enable is high. With a nominal base clock near 41.78 MHz, the slowest setting gives roughly 326 kHz.

The mode code selects active operation or one of four low-power states: pause, nap, sleep and stop. In every low-power state the core clock enable stays low. Each state has its own set of wake sources. Pause, nap and sleep leave on any of the four external interrupt lines or on the timer request. Stop leaves only on an external interrupt. A wake returns the block to active mode and raises a one-cycle wake flag. The divide counter then restarts from zero.

Top module: `pwr_clk_ctrl`

## Requirements
- R1: After reset the state output is 000 (active), the wake flag is low, and the divide code is 3. The first core clock enable appears in the 8th cycle after reset is released.
- R2: While active with divide code c (0 to 7), the core clock enable is high for one reference cycle in every 2^c cycles. With c = 0 it is high in every cycle.
- R3: Any load restarts the divide count. The first enable after a load with code c falls in the 2^c-th cycle following the loading edge.
- R4: A load with mode code 000 active, 001 pause, 010 nap, 011 sleep or 100 stop shows that code on the state output from the next cycle. The state output never shows a value above 100.
- R5: A load with a reserved mode code (101, 110, 111) leaves the state unchanged. Its divide code still takes effect.
- R6: In pause, nap, sleep and stop the core clock enable stays low, and with no wake source and no load the state holds.
- R7: In pause, nap or sleep, any external interrupt line or the timer request moves the state to active on the next edge.
- R8: In stop, the timer request is ignored: the state stays 100 and no wake flag is raised. Only an external interrupt line wakes it.
- R9: A wake raises the wake flag for exactly one cycle, in the same cycle the state reads active. Wake sources seen while already active raise no flag.
- R10: When a wake source and a load arrive in the same cycle during a low-power state, the wake takes precedence for the mode: the state goes to active and the flag rises. The divide code of the load still takes effect.
- R11: After a wake, the first core clock enable falls in the 2^c-th cycle after the waking edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 3 | Operating-mode code from the control register |
| cfg_div | input | 3 | Clock divide code from the control register |
| cfg_load | input | 1 | Strobe that loads both codes |
| ext_irq | input | 4 | External interrupt wake lines |
| tmr_wake | input | 1 | Timer wake request |
| core_ce | output | 1 | Core clock enable pulse |
| pwr_state | output | 3 | Current power state code |
| wake_evt | output | 1 | One-cycle wake flag |

## Verification
In a low-power state, a load strobe and a wake source can reach the mode register in the same cycle. The bench provokes this in nap by raising an interrupt line and a load that asks for stop with a new divide code on the same edge. It then expects the state to read active with the wake flag set. It also expects the first enable to follow the new divide code, which confirms that the divide half of the load was kept while its mode half was dropped.

// File: rtl/pwr_pkg.sv
// Package: shared power-state encoding and code helpers.
// Assumes mode codes above 3'b100 are reserved.
package pwr_pkg;

    typedef enum logic [2:0] {
        PM_ACTIVE = 3'b000,
        PM_PAUSE  = 3'b001,
        PM_NAP    = 3'b010,
        PM_SLEEP  = 3'b011,
        PM_STOP   = 3'b100
    } pmode_e;

    // True when the code names one of the five defined states.
    function automatic logic mode_is_legal(input logic [2:0] code);
        return code <= 3'b100;
    endfunction

endpackage

// File: rtl/pwr_wake_sel.sv
// Module: pwr_wake_sel
// Combines the wake sources that are valid for the present state into one
// wake request. Assumes the sources are already synchronous to clk. Active
// mode never requests a wake, and stop does not listen to the timer.
module pwr_wake_sel
    import pwr_pkg::*;
#(
    parameter int N_IRQ = 4
) (
    input  pmode_e            state,
    input  logic [N_IRQ-1:0]  ext_irq,
    input  logic              tmr_wake,
    output logic              wake_req
);

    logic any_irq;
    logic timer_ok;

    // Pick the sources that count in the present low-power state.
    always_comb begin
        any_irq  = |ext_irq;
        timer_ok = tmr_wake && (state != PM_STOP);
        wake_req = (state != PM_ACTIVE) && (any_irq || timer_ok);
    end

endmodule

// File: rtl/pwr_mode_fsm.sv
// Module: pwr_mode_fsm
// Holds the power state. A wake takes precedence over a load. A load with a
// reserved code is dropped. Assumes wake_req is only high in a low-power
// state.
module pwr_mode_fsm
    import pwr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [2:0] mode_code,
    input  logic       wake_req,
    output pmode_e     state,
    output logic       wake_evt
);

    // Update the state and the one-cycle wake flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= PM_ACTIVE;
            wake_evt <= 1'b0;
        end else begin
            wake_evt <= wake_req;
            if (wake_req) begin
                state <= PM_ACTIVE;
            end else if (load && mode_is_legal(mode_code)) begin
                state <= pmode_e'(mode_code);
            end
        end
    end

endmodule

// File: rtl/clk_div_gen.sv
// Module: clk_div_gen
// Power-of-two clock-enable divider. It pulses ce once every 2^div_q cycles
// while run is high. The count clears on every load and whenever run is low.
// Assumes DIV_W is small, since the counter is 2^DIV_W - 1 bits wide.
module clk_div_gen #(
    parameter int         DIV_W   = 3,
    parameter logic [2:0] RST_DIV = 3'd3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DIV_W-1:0] div_code,
    input  logic             run,
    output logic             ce
);

    localparam int CNT_W = (1 << DIV_W) - 1;

    logic [DIV_W-1:0] div_q;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   one_sh;
    logic [CNT_W-1:0] limit;
    logic             at_limit;

    // Terminal count for the held divide code: 2^div_q - 1.
    always_comb begin
        one_sh   = {{CNT_W{1'b0}}, 1'b1} << div_q;
        limit    = one_sh[CNT_W-1:0] - {{(CNT_W-1){1'b0}}, 1'b1};
        at_limit = (cnt == limit);
        ce       = run && at_limit;
    end

    // Hold the divide code and advance or clear the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= DIV_W'(RST_DIV);
            cnt   <= '0;
        end else if (load) begin
            div_q <= div_code;
            cnt   <= '0;
        end else if (!run || at_limit) begin
            cnt   <= '0;
        end else begin
            cnt   <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/pwr_clk_ctrl.sv
// Module: pwr_clk_ctrl (top)
// Power-mode controller with a core clock-enable divider. Register fields
// arrive with a load strobe. The divider runs only in active mode.
// Assumes every input is synchronous to clk.
module pwr_clk_ctrl
    import pwr_pkg::*;
#(
    parameter int N_IRQ = 4,
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       cfg_mode,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             cfg_load,
    input  logic [N_IRQ-1:0] ext_irq,
    input  logic             tmr_wake,
    output logic             core_ce,
    output logic [2:0]       pwr_state,
    output logic             wake_evt
);

    pmode_e state;
    logic   wake_req;
    logic   running;

    // Expose the state code and derive the divider run qualifier.
    always_comb begin
        pwr_state = state;
        running   = (state == PM_ACTIVE);
    end

    pwr_wake_sel #(.N_IRQ(N_IRQ)) u_wake (
        .state    (state),
        .ext_irq  (ext_irq),
        .tmr_wake (tmr_wake),
        .wake_req (wake_req)
    );

    pwr_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (cfg_load),
        .mode_code (cfg_mode),
        .wake_req  (wake_req),
        .state     (state),
        .wake_evt  (wake_evt)
    );

    clk_div_gen #(.DIV_W(DIV_W), .RST_DIV(3'd3)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cfg_load),
        .div_code (cfg_div),
        .run      (running),
        .ce       (core_ce)
    );

endmodule

// File: rtl/pwr_clk_ctrl_chk.sv
// Module: pwr_clk_ctrl_chk
// Port-level property checker for pwr_clk_ctrl, attached by bind.
module pwr_clk_ctrl_chk #(
    parameter int N_IRQ = 4,
    parameter int DIV_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       cfg_mode,
    input logic [DIV_W-1:0] cfg_div,
    input logic             cfg_load,
    input logic [N_IRQ-1:0] ext_irq,
    input logic             tmr_wake,
    input logic             core_ce,
    input logic [2:0]       pwr_state,
    input logic             wake_evt
);

    logic div_seen;
    // The divide code has no property of its own here.
    assign div_seen = |cfg_div;

    assert_legal_state_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_state <= 3'd4);

    assert_reserved_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 3'd0 && cfg_load && cfg_mode > 3'd4) |=> (pwr_state == 3'd0));

    assert_ce_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state != 3'd0) |-> !core_ce);

    assert_lp_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state != 3'd0 && ext_irq == '0 && !tmr_wake && !cfg_load)
        |=> $stable(pwr_state));

    assert_sleep_timer_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 3'd3 && tmr_wake) |=> (pwr_state == 3'd0 && wake_evt));

    assert_stop_timer_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 3'd4 && ext_irq == '0 && !cfg_load)
        |=> (pwr_state == 3'd4 && !wake_evt));

    assert_wake_active_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_evt |-> (pwr_state == 3'd0));

    assert_wake_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_evt |=> !wake_evt);

    assert_collision_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state != 3'd0 && (|ext_irq) && cfg_load && div_seen | !div_seen)
        |=> (pwr_state == 3'd0 && wake_evt));

endmodule

bind pwr_clk_ctrl pwr_clk_ctrl_chk #(.N_IRQ(N_IRQ), .DIV_W(DIV_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_mode  (cfg_mode),
    .cfg_div   (cfg_div),
    .cfg_load  (cfg_load),
    .ext_irq   (ext_irq),
    .tmr_wake  (tmr_wake),
    .core_ce   (core_ce),
    .pwr_state (pwr_state),
    .wake_evt  (wake_evt)
);

// File: tb/tb_pwr_clk_ctrl.sv
// Directed bench for pwr_clk_ctrl. It drives inputs and samples outputs on
// the falling edge.
module tb_pwr_clk_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYC   = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cfg_mode = 3'd0;
    logic [2:0] cfg_div = 3'd0;
    logic       cfg_load = 1'b0;
    logic [3:0] ext_irq = 4'd0;
    logic       tmr_wake = 1'b0;
    logic       core_ce;
    logic [2:0] pwr_state;
    logic       wake_evt;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_clk_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_div(cfg_div),
        .cfg_load(cfg_load), .ext_irq(ext_irq), .tmr_wake(tmr_wake),
        .core_ce(core_ce), .pwr_state(pwr_state), .wake_evt(wake_evt)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Load both codes. Returns at the falling edge just after the loading edge.
    task automatic load_cfg(input logic [2:0] m, input logic [2:0] d);
        @(negedge clk);
        cfg_mode = m; cfg_div = d; cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    // Start at the 1st cycle after a restart. Check the 1st and 2nd enable index.
    task automatic measure_ce(input int c, input string req);
        int cnt = 1, first = 0, second = 0;
        while (second == 0 && cnt < 600) begin
            if (core_ce) begin
                if (first == 0) first = cnt;
                else second = cnt;
            end
            if (second == 0) begin
                @(negedge clk);
                cnt++;
            end
        end
        chk({req, " first enable"}, first, 1 << c);
        chk({req, " enable period"}, second - first, 1 << c);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 state", pwr_state, 0);
        chk("R1 wake flag", wake_evt, 0);
        measure_ce(3, "R1");
    endtask

    task automatic t_all_divs();
        for (int c = 0; c < 8; c++) begin
            load_cfg(3'd0, c[2:0]);
            measure_ce(c, "R2");
        end
    endtask

    task automatic t_restart();
        load_cfg(3'd0, 3'd4);
        repeat (5) @(negedge clk);
        load_cfg(3'd0, 3'd4);           // same code mid-count: restart
        measure_ce(4, "R3");
    endtask

    task automatic t_reserved();
        load_cfg(3'd5, 3'd1);
        chk("R5 reserved in active", pwr_state, 0);
        measure_ce(1, "R5 divide taken");
        load_cfg(3'd3, 3'd1);
        load_cfg(3'd7, 3'd2);
        chk("R5 reserved in sleep", pwr_state, 3);
        ext_irq = 4'b0001;
        @(negedge clk);
        ext_irq = 4'b0000;
        chk("R5 wake after reserved", pwr_state, 0);
        measure_ce(2, "R5 divide taken in sleep");
    endtask

    // Enter mode m, hold, wake with the given sources, then check the restart.
    task automatic t_wake(input logic [2:0] m, input logic [3:0] irqv,
                          input logic tmr, input string req);
        int ce_seen = 0;
        load_cfg(m, 3'd1);
        chk({"R4 state after load ", req}, pwr_state, m);
        repeat (4) begin
            @(negedge clk);
            ce_seen += core_ce;
        end
        chk({"R6 enable low ", req}, ce_seen, 0);
        chk({"R6 state held ", req}, pwr_state, m);
        ext_irq = irqv; tmr_wake = tmr;
        @(negedge clk);
        ext_irq = 4'd0; tmr_wake = 1'b0;
        chk({req, " state active after wake"}, pwr_state, 0);
        chk({"R9 wake flag high ", req}, wake_evt, 1);
        chk({"R11 no enable in 1st cycle ", req}, core_ce, 0);
        @(negedge clk);
        chk({"R9 wake flag one cycle ", req}, wake_evt, 0);
        chk({"R11 enable in 2nd cycle ", req}, core_ce, 1);
    endtask

    task automatic t_stop_timer();
        int bad = 0;
        load_cfg(3'd4, 3'd2);
        tmr_wake = 1'b1;
        repeat (6) begin
            @(negedge clk);
            if (pwr_state != 3'd4 || wake_evt || core_ce) bad++;
        end
        tmr_wake = 1'b0;
        chk("R8 timer ignored in stop", bad, 0);
        ext_irq = 4'b0100;
        @(negedge clk);
        ext_irq = 4'd0;
        chk("R8 interrupt wakes stop", pwr_state, 0);
        chk("R8 wake flag", wake_evt, 1);
        measure_ce(2, "R11 after stop");
    endtask

    task automatic t_active_sources();
        int flags = 0;
        load_cfg(3'd0, 3'd0);
        ext_irq = 4'b1111; tmr_wake = 1'b1;
        repeat (3) begin
            @(negedge clk);
            flags += wake_evt;
        end
        ext_irq = 4'd0; tmr_wake = 1'b0;
        chk("R9 no flag while active", flags, 0);
    endtask

    task automatic t_collision();
        load_cfg(3'd2, 3'd0);
        @(negedge clk);
        ext_irq = 4'b0001; cfg_mode = 3'd4; cfg_div = 3'd2; cfg_load = 1'b1;
        @(negedge clk);
        ext_irq = 4'd0; cfg_load = 1'b0;
        chk("R10 wake beats load", pwr_state, 0);
        chk("R10 wake flag", wake_evt, 1);
        measure_ce(2, "R10 divide kept");
    endtask

    task automatic t_load_exit();
        load_cfg(3'd1, 3'd3);
        load_cfg(3'd0, 3'd0);
        chk("R4 load to active", pwr_state, 0);
        chk("R4 load exit raises no flag", wake_evt, 0);
        measure_ce(0, "R4 after load exit");
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        t_reset();
        t_all_divs();
        t_restart();
        t_reserved();
        t_wake(3'd1, 4'b0010, 1'b0, "R7 pause irq1");
        t_wake(3'd2, 4'b0000, 1'b1, "R7 nap timer");
        t_wake(3'd3, 4'b1000, 1'b0, "R7 sleep irq3");
        t_wake(3'd3, 4'b0000, 1'b1, "R7 sleep timer");
        t_stop_timer();
        t_active_sources();
        t_collision();
        t_load_exit();
        done = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", WDOG_CYC);
            report();
            $finish;
        end
    end

endmodule